// File: doc/BRIEF.md
# Exception entry sequencer

This block is the control logic in a small processor core that switches it from normal execution into a handler for a fast interrupt, a normal interrupt or a software trap, and back again. The two external request lines pass through a resynchronizing flop chain. The sequencer then waits until the core reports that the current instruction has completed. It spends two cycles on entry. In the first it saves the return address and a copy of the status word. In the second it forces the mode and disable bits and issues a one-cycle program-counter load with a fixed vector address.

A return instruction reloads the status word and the program counter from the saved copies that belong to the current mode. The saved copies are kept per handler mode, so a fast interrupt may nest inside a normal-interrupt handler and both returns unwind correctly. The core stalls its pipeline while `busy_o` is high and takes `pc_next_o` whenever `pc_load_o` pulses.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status word is 0 (user mode, both disable bits clear), and `busy_o`, `pc_load_o` and `trap_arg_o` are 0.
- R2: An external request is seen only after two flop stages. With `insn_done_i` held high, a request that is raised before clock edge k makes `busy_o` rise after edge k+2 and not before.
- R3: An accepted entry keeps `busy_o` high for exactly two cycles. In the cycle after `busy_o` falls, `pc_load_o` is high for one cycle.
- R4: No entry begins while `insn_done_i` is low, however long a request has been pending.
- R5: When both synchronized requests are enabled in the same cycle, the fast interrupt is taken.
- R6: The status word is bit 3 fast-disable, bit 2 normal-disable and bits 1:0 mode (0 user, 1 fast, 2 normal, 3 supervisor). Fast entry sets both disable bits and mode 1. Normal entry sets bit 2 and mode 2 and leaves bit 3 unchanged. A request whose disable bit is set is not taken.
- R7: The loaded vector is 0x1C for the fast interrupt, 0x18 for the normal interrupt and 0x08 for a trap.
- R8: A trap (`swi_i` with `insn_done_i`) wins over pending interrupts. It sets mode 3 and bit 2, leaves bit 3 unchanged, and presents its argument field on `trap_arg_o`, which holds until the next trap.
- R9: On entry the return address from `ret_addr_i` and the prior status word are saved for the target mode. A return (`ret_i` with `insn_done_i`) in a handler mode loads that mode's saved address into `pc_next_o` with `pc_load_o` in the next cycle, and restores that mode's saved status word. Nested fast-in-normal entries unwind in order.
- R10: A return issued in user mode has no effect: no load pulse, no change to the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fiq_req_i | input | 1 | Asynchronous fast interrupt request, level |
| irq_req_i | input | 1 | Asynchronous normal interrupt request, level |
| insn_done_i | input | 1 | Current instruction has completed |
| swi_i | input | 1 | Completing instruction is a software trap |
| swi_arg_i | input | ARG_W | Argument field of the trap instruction |
| ret_i | input | 1 | Completing instruction is a handler return |
| ret_addr_i | input | PC_W | Address to resume at after a handler |
| pc_load_o | output | 1 | One-cycle program-counter load strobe |
| pc_next_o | output | PC_W | Value to load into the program counter |
| status_o | output | 4 | Current status word |
| busy_o | output | 1 | Entry in progress; core must stall |
| trap_arg_o | output | ARG_W | Argument of the most recent trap |

## Verification
The bench builds the block with a 32-bit address, a 24-bit trap argument and the two-stage synchronizer, so the exact rise cycle of `busy_o` after a request can be pinned down. With these values a short run reaches every corner: simultaneous requests, masked requests held across many cycles, a fast interrupt nested inside a normal handler with both returns, a trap that arrives while a request is pending, and a stray return in user mode. A behavioural model in the bench tracks the saved copies per mode and is compared with every output on every cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    MODE_USR = 2'd0,
    MODE_FIQ = 2'd1,
    MODE_IRQ = 2'd2,
    MODE_SVC = 2'd3
  } cpu_mode_e;

  typedef struct packed {
    logic      fdis;
    logic      idis;
    cpu_mode_e mode;
  } stat_t;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_TRAP = 2'd1,
    CLS_FIQ  = 2'd2,
    CLS_IRQ  = 2'd3
  } exc_cls_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SAVE  = 2'd1,
    PH_FORCE = 2'd2
  } phase_e;

  localparam int unsigned NUM_BANKS = 3;

  function automatic cpu_mode_e mode_of(exc_cls_e c);
    case (c)
      CLS_FIQ:  return MODE_FIQ;
      CLS_IRQ:  return MODE_IRQ;
      CLS_TRAP: return MODE_SVC;
      default:  return MODE_USR;
    endcase
  endfunction

  function automatic stat_t force_stat(exc_cls_e c, stat_t cur);
    stat_t r;
    r = cur;
    case (c)
      CLS_FIQ: begin
        r.fdis = 1'b1;
        r.idis = 1'b1;
        r.mode = MODE_FIQ;
      end
      CLS_IRQ: begin
        r.idis = 1'b1;
        r.mode = MODE_IRQ;
      end
      CLS_TRAP: begin
        r.idis = 1'b1;
        r.mode = MODE_SVC;
      end
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic req_o
);

  logic [STAGES-1:0] q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q[0] <= 1'b0;
          else     q[0] <= req_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q[g] <= 1'b0;
          else     q[g] <= q[g-1];
        end
      end
    end
  endgenerate

  assign req_o = q[STAGES-1];

  // R2: the first stage follows the raw input by exactly one edge
  a_r2_first_stage: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q[0] == $past(req_i)));

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic     idle_i,
  input  logic     done_i,
  input  logic     ret_i,
  input  logic     swi_i,
  input  logic     fiq_i,
  input  logic     irq_i,
  input  stat_t    stat_i,
  output logic     take_ret_o,
  output exc_cls_e sel_o
);

  logic slot;

  always_comb begin
    slot       = idle_i && done_i;
    take_ret_o = slot && ret_i && (stat_i.mode != MODE_USR);
    sel_o      = CLS_NONE;
    if (slot && !take_ret_o) begin
      if (swi_i)                     sel_o = CLS_TRAP;
      else if (fiq_i && !stat_i.fdis) sel_o = CLS_FIQ;
      else if (irq_i && !stat_i.idis) sel_o = CLS_IRQ;
    end
  end

  always_comb begin
    // R5: fast request wins over normal request when both are enabled
    if (slot && !ret_i && !swi_i && fiq_i && irq_i && !stat_i.fdis && !stat_i.idis)
      a_r5_fiq_first: assert (sel_o == CLS_FIQ);
    // R6: a masked normal request is never chosen
    if (stat_i.idis)
      a_r6_irq_masked: assert (sel_o != CLS_IRQ);
  end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  cpu_mode_e       wr_mode_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  stat_t           wr_stat_i,
  input  cpu_mode_e       rd_mode_i,
  output logic [PC_W-1:0] rd_pc_o,
  output stat_t           rd_stat_o
);

  logic [NUM_BANKS-1:0][PC_W-1:0] pc_q;
  stat_t [NUM_BANKS-1:0]          st_q;

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          pc_q[g] <= '0;
          st_q[g] <= '0;
        end else if (we_i && (wr_mode_i == cpu_mode_e'(2'(g + 1)))) begin
          pc_q[g] <= wr_pc_i;
          st_q[g] <= wr_stat_i;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_pc_o   = '0;
    rd_stat_o = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rd_mode_i == cpu_mode_e'(2'(i + 1))) begin
        rd_pc_o   = pc_q[i];
        rd_stat_o = st_q[i];
      end
    end
  end

  // R9: saved copies change only on an entry write
  a_r9_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> ($stable(pc_q) && $stable(st_q)));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned ARG_W       = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_TRAP    = 32'h08,
  parameter int unsigned VEC_IRQ     = 32'h18,
  parameter int unsigned VEC_FIQ     = 32'h1C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fiq_req_i,
  input  logic             irq_req_i,
  input  logic             insn_done_i,
  input  logic             swi_i,
  input  logic [ARG_W-1:0] swi_arg_i,
  input  logic             ret_i,
  input  logic [PC_W-1:0]  ret_addr_i,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_next_o,
  output logic [3:0]       status_o,
  output logic             busy_o,
  output logic [ARG_W-1:0] trap_arg_o
);

  localparam logic [PC_W-1:0] V_TRAP = PC_W'(VEC_TRAP);
  localparam logic [PC_W-1:0] V_IRQ  = PC_W'(VEC_IRQ);
  localparam logic [PC_W-1:0] V_FIQ  = PC_W'(VEC_FIQ);

  function automatic logic [PC_W-1:0] vec_of(exc_cls_e c);
    case (c)
      CLS_FIQ:  return V_FIQ;
      CLS_IRQ:  return V_IRQ;
      default:  return V_TRAP;
    endcase
  endfunction

  phase_e           phase_q;
  exc_cls_e         cls_q;
  logic [PC_W-1:0]  cap_pc_q;
  stat_t            stat_q;
  logic             pc_load_q;
  logic [PC_W-1:0]  pc_next_q;
  logic             busy_q;
  logic [ARG_W-1:0] arg_q;

  logic             fiq_s, irq_s;
  logic             take_ret;
  exc_cls_e         sel;
  logic [PC_W-1:0]  rd_pc;
  stat_t            rd_stat;

  exc_sync #(.STAGES(SYNC_STAGES)) u_sync_fiq (
    .clk(clk), .rst(rst), .req_i(fiq_req_i), .req_o(fiq_s)
  );

  exc_sync #(.STAGES(SYNC_STAGES)) u_sync_irq (
    .clk(clk), .rst(rst), .req_i(irq_req_i), .req_o(irq_s)
  );

  exc_arbiter u_arb (
    .idle_i    (phase_q == PH_IDLE),
    .done_i    (insn_done_i),
    .ret_i     (ret_i),
    .swi_i     (swi_i),
    .fiq_i     (fiq_s),
    .irq_i     (irq_s),
    .stat_i    (stat_q),
    .take_ret_o(take_ret),
    .sel_o     (sel)
  );

  exc_bank #(.PC_W(PC_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we_i     (phase_q == PH_SAVE),
    .wr_mode_i(mode_of(cls_q)),
    .wr_pc_i  (cap_pc_q),
    .wr_stat_i(stat_q),
    .rd_mode_i(stat_q.mode),
    .rd_pc_o  (rd_pc),
    .rd_stat_o(rd_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cls_q     <= CLS_NONE;
      cap_pc_q  <= '0;
      stat_q    <= '0;
      pc_load_q <= 1'b0;
      pc_next_q <= '0;
      busy_q    <= 1'b0;
      arg_q     <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          pc_load_q <= 1'b0;
          if (take_ret) begin
            stat_q    <= rd_stat;
            pc_next_q <= rd_pc;
            pc_load_q <= 1'b1;
          end else if (sel != CLS_NONE) begin
            cls_q    <= sel;
            cap_pc_q <= ret_addr_i;
            busy_q   <= 1'b1;
            phase_q  <= PH_SAVE;
            if (sel == CLS_TRAP) arg_q <= swi_arg_i;
          end
        end
        PH_SAVE: begin
          phase_q <= PH_FORCE;
        end
        PH_FORCE: begin
          stat_q    <= force_stat(cls_q, stat_q);
          pc_next_q <= vec_of(cls_q);
          pc_load_q <= 1'b1;
          busy_q    <= 1'b0;
          phase_q   <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign pc_load_o  = pc_load_q;
  assign pc_next_o  = pc_next_q;
  assign status_o   = stat_q;
  assign busy_o     = busy_q;
  assign trap_arg_o = arg_q;

  // R3: entry occupies exactly two busy cycles
  a_r3_busy_len: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |=> busy_q ##1 !busy_q);

  // R3: the load strobe follows the end of entry
  a_r3_load_after: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> pc_load_q);

  // R4: entry only starts after a completed instruction
  a_r4_wait_done: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(insn_done_i));

  // R6: fast entry leaves both disables set
  a_r6_fiq_masks: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FORCE && cls_q == CLS_FIQ) |=>
      (stat_q.fdis && stat_q.idis && stat_q.mode == MODE_FIQ));

  // R7: load value after entry matches the class vector
  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FORCE) |=> (pc_next_q == vec_of($past(cls_q))));

  // R8: trap argument only changes when a trap is accepted
  a_r8_arg_hold: assert property (@(posedge clk) disable iff (rst)
    !(sel == CLS_TRAP) |=> $stable(arg_q));

  // R10: a return in user mode produces no load
  a_r10_user_ret: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && insn_done_i && ret_i && stat_q.mode == MODE_USR) |=> !pc_load_q);

endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

  localparam int PC_W  = 32;
  localparam int ARG_W = 24;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fiq_req_i = 1'b0, irq_req_i = 1'b0;
  logic             insn_done_i = 1'b0, swi_i = 1'b0, ret_i = 1'b0;
  logic [ARG_W-1:0] swi_arg_i = '0;
  logic [PC_W-1:0]  ret_addr_i = '0;
  logic             pc_load_o, busy_o;
  logic [PC_W-1:0]  pc_next_o;
  logic [3:0]       status_o;
  logic [ARG_W-1:0] trap_arg_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  exc_entry_seq #(.PC_W(PC_W), .ARG_W(ARG_W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .fiq_req_i(fiq_req_i), .irq_req_i(irq_req_i),
    .insn_done_i(insn_done_i), .swi_i(swi_i), .swi_arg_i(swi_arg_i),
    .ret_i(ret_i), .ret_addr_i(ret_addr_i), .pc_load_o(pc_load_o),
    .pc_next_o(pc_next_o), .status_o(status_o), .busy_o(busy_o),
    .trap_arg_o(trap_arg_o)
  );

  // behavioural reference model
  int          m_phase, m_cls;
  logic [31:0] m_cap, m_pcn, m_arg;
  logic [3:0]  m_stat;
  logic        m_load, m_busy;
  logic [31:0] b_pc [4];
  logic [3:0]  b_st [4];
  logic        f_pipe [SYNC];
  logic        i_pipe [SYNC];

  function automatic logic [3:0] forced(int cls, logic [3:0] s);
    if (cls == 1) return 4'b1101;
    if (cls == 2) return {s[3], 3'b110};
    return {s[3], 3'b111};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cls = 0; m_cap = 0; m_pcn = 0; m_arg = 0;
      m_stat = 0; m_load = 0; m_busy = 0;
      for (int k = 0; k < 4; k++) begin b_pc[k] = 0; b_st[k] = 0; end
      for (int k = 0; k < SYNC; k++) begin f_pipe[k] = 0; i_pipe[k] = 0; end
    end else begin
      if (m_phase == 0) begin
        m_load = 0;
        if (insn_done_i && ret_i && m_stat[1:0] != 0) begin
          m_pcn = b_pc[m_stat[1:0]];
          m_stat = b_st[m_stat[1:0]];
          m_load = 1;
        end else if (insn_done_i) begin
          m_cls = 0;
          if (swi_i) m_cls = 3;
          else if (f_pipe[SYNC-1] && !m_stat[3]) m_cls = 1;
          else if (i_pipe[SYNC-1] && !m_stat[2]) m_cls = 2;
          if (m_cls != 0) begin
            m_cap = ret_addr_i; m_busy = 1; m_phase = 1;
            if (m_cls == 3) m_arg = 32'(swi_arg_i);
          end
        end
      end else if (m_phase == 1) begin
        b_pc[m_cls] = m_cap; b_st[m_cls] = m_stat;
        m_phase = 2;
      end else begin
        m_stat = forced(m_cls, m_stat);
        m_pcn = (m_cls == 1) ? 32'h1C : (m_cls == 2) ? 32'h18 : 32'h08;
        m_load = 1; m_busy = 0; m_phase = 0;
      end
      for (int k = SYNC - 1; k > 0; k--) begin
        f_pipe[k] = f_pipe[k-1]; i_pipe[k] = i_pipe[k-1];
      end
      f_pipe[0] = fiq_req_i; i_pipe[0] = irq_req_i;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R7 load strobe",  32'(pc_load_o), 32'(m_load));
      check("R9 pc value",     pc_next_o, m_pcn);
      check("R6 status word",  32'(status_o), 32'(m_stat));
      check("R3 busy",         32'(busy_o), 32'(m_busy));
      check("R8 trap arg",     32'(trap_arg_o), m_arg);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_load();
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pc_load_o) return;
    end
  endtask

  task automatic do_ret();
    ret_i = 1'b1;
    @(negedge clk);
    ret_i = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset status", 32'(status_o), 0);
    check("R1 reset busy", 32'(busy_o), 0);
    check("R1 reset load", 32'(pc_load_o), 0);
    check("R1 reset arg", 32'(trap_arg_o), 0);

    // R2 synchronizer latency, normal interrupt
    ret_addr_i = 32'h100; insn_done_i = 1'b1; irq_req_i = 1'b1;
    @(negedge clk); check("R2 no entry after 1 edge", 32'(busy_o), 0);
    @(negedge clk); check("R2 no entry after 2 edges", 32'(busy_o), 0);
    @(negedge clk); check("R2 entry after 3 edges", 32'(busy_o), 1);
    @(negedge clk); check("R3 busy second cycle", 32'(busy_o), 1);
    @(negedge clk);
    check("R3 load pulse", 32'(pc_load_o), 1);
    check("R7 irq vector", pc_next_o, 32'h18);
    check("R6 irq status", 32'(status_o), 32'h6);
    irq_req_i = 1'b0;
    cyc(4);
    do_ret();
    check("R9 return pc", pc_next_o, 32'h100);
    check("R9 return status", 32'(status_o), 0);

    // R4 wait for instruction completion
    insn_done_i = 1'b0; irq_req_i = 1'b1; ret_addr_i = 32'h140;
    cyc(8);
    check("R4 no entry without done", 32'(busy_o), 0);
    insn_done_i = 1'b1;
    @(negedge clk); check("R4 entry once done", 32'(busy_o), 1);
    wait_load();
    check("R7 irq vector again", pc_next_o, 32'h18);
    irq_req_i = 1'b0; cyc(4); do_ret();

    // R5 simultaneous requests, R6 masking
    ret_addr_i = 32'h200; fiq_req_i = 1'b1; irq_req_i = 1'b1;
    wait_load();
    check("R5 fast wins", pc_next_o, 32'h1C);
    check("R6 fast status", 32'(status_o), 32'hD);
    cyc(6);
    check("R6 masked while in fast handler", 32'(busy_o), 0);
    fiq_req_i = 1'b0; cyc(3);
    ret_addr_i = 32'h300;
    do_ret();
    check("R9 fast return pc", pc_next_o, 32'h200);
    wait_load();
    check("R7 pending normal taken", pc_next_o, 32'h18);
    // nested fast inside normal handler
    ret_addr_i = 32'h400; fiq_req_i = 1'b1;
    wait_load();
    check("R9 nested fast vector", pc_next_o, 32'h1C);
    fiq_req_i = 1'b0; irq_req_i = 1'b0; cyc(4);
    do_ret();
    check("R9 nested return pc", pc_next_o, 32'h400);
    check("R9 nested return status", 32'(status_o), 32'h6);
    cyc(2); do_ret();
    check("R9 outer return pc", pc_next_o, 32'h300);
    check("R9 outer return status", 32'(status_o), 0);

    // R8 trap beats a pending request
    insn_done_i = 1'b0; irq_req_i = 1'b1; cyc(4);
    insn_done_i = 1'b1; swi_i = 1'b1; swi_arg_i = 24'hABCDE; ret_addr_i = 32'h500;
    @(negedge clk);
    swi_i = 1'b0;
    wait_load();
    check("R8 trap vector", pc_next_o, 32'h08);
    check("R8 trap status", 32'(status_o), 32'h7);
    check("R8 trap arg", 32'(trap_arg_o), 32'hABCDE);
    irq_req_i = 1'b0; cyc(4); do_ret();
    check("R9 trap return pc", pc_next_o, 32'h500);

    // R10 return in user mode
    cyc(2);
    do_ret();
    check("R10 no load in user mode", 32'(pc_load_o), 0);
    cyc(3);
    check("R10 status unchanged", 32'(status_o), 0);
    check("R8 arg held", 32'(trap_arg_o), 32'hABCDE);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule